// File: doc/BRIEF.md
# Addressable LED strip serializer

This block keeps a small colour store for a chain of single-wire RGB LEDs and plays it out on one serial data line, over and over, without help from the host. The host writes a pixel by giving an index and three 8-bit colour values. Each value is scaled by a global dimming level before it is stored. The dimming level is held in a register inside the block and is written through its own strobe. Out-of-range indices wrap around the chain. A clear strobe blanks every pixel at once.

The line carries one bit per fixed-length slot of 1.25 µs. The number of clocks per slot is the clock frequency divided by 800000. A bit begins with the line high, and the high time tells the strip whether the bit is a 0 or a 1. After the last pixel the line idles low for a latch gap. The frame then starts again from pixel 0.

Top module: `led_strip_serializer`

## Requirements
- R1: Inside a frame, successive bit pulses start exactly SLOT = CLK_HZ/800000 clocks apart. Every division here is integer division.
- R2: A 0 bit holds the line high for SLOT/3 clocks. A 1 bit holds it high for (SLOT/3)*2 clocks. The line is low for the rest of the slot.
- R3: A frame sends pixel 0 first and then the higher indices. Each pixel is 24 bits in the order green byte, red byte, blue byte, and each byte is sent most significant bit first.
- R4: After the last bit of the last pixel, the line stays low for GAP_SLOTS (50) whole slots. The first pulse of the next frame therefore starts (GAP_SLOTS+1)*SLOT clocks after the last pulse began. Frames repeat forever without host action, and each frame holds exactly 24*PIXELS pulses.
- R5: A stored colour byte is floor(value * dim / 256). The dimming register comes out of reset at 255.
- R6: A write to an index at or above PIXELS stores to index modulo PIXELS.
- R7: A clear strobe sets every pixel to zero, and it takes priority over a pixel write in the same cycle. Zero pixels are still sent, as 24 short pulses each.
- R8: While reset is high the line is low. After reset the block first idles for a full latch gap, and only then sends pixel 0, so the first pulse comes about GAP_SLOTS*SLOT clocks after reset falls.
- R9: Dimming applies when a pixel is written. A later change of the dimming level leaves stored pixels as they were and affects only later writes. A write in the same cycle as a dimming change uses the old level.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous reset, active high |
| dim_we | input | 1 | Load strobe for the dimming register |
| dim_level | input | 8 | New dimming level (0..255) |
| px_we | input | 1 | Pixel write strobe |
| px_index | input | IDX_W | Pixel index, wrapped modulo PIXELS |
| px_red | input | 8 | Red value before dimming |
| px_green | input | 8 | Green value before dimming |
| px_blue | input | 8 | Blue value before dimming |
| clr_all | input | 1 | Clears every stored pixel |
| led_dout | output | 1 | Serial data line to the LED chain |

## Verification
Each stimulus pattern is followed by a whole captured frame, and every pulse width is decoded into a bit and compared with an independent model of the store. The all-zero frame after reset shows that blank pixels still produce short pulses. Distinct per-channel values at full dimming expose any mistake in byte order, bit order or pixel order. Indices past the end show whether wrapping hits the right slot. Changing the dimming level between writes separates scaling at write time from scaling at send time. A level of 0 and a clear show that the store really empties. Frames left to run with no host activity confirm the fixed pulse period, the gap length and the pulse count per frame.

// File: rtl/led_ser_pkg.sv
package led_ser_pkg;

    localparam int BITS_PER_PIXEL = 24;

    // Packed so that bit 23 is the first bit on the wire (green MSB).
    typedef struct packed {
        logic [7:0] grn;
        logic [7:0] red;
        logic [7:0] blu;
    } pixel_t;

    typedef enum logic {
        PH_GAP  = 1'b0,
        PH_DATA = 1'b1
    } phase_e;

    function automatic logic [7:0] dim_scale(input logic [7:0] v, input logic [7:0] lvl);
        logic [15:0] prod;
        prod = 16'(v) * 16'(lvl);
        return prod[15:8];
    endfunction

endpackage

// File: rtl/led_write_path.sv
module led_write_path
    import led_ser_pkg::*;
#(
    parameter int PIXELS = 8,
    parameter int IDX_W  = 8,
    parameter int PAW    = 3
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             dim_we,
    input  logic [7:0]       dim_level,
    input  logic             px_we,
    input  logic [IDX_W-1:0] px_index,
    input  logic [7:0]       px_red,
    input  logic [7:0]       px_green,
    input  logic [7:0]       px_blue,
    output logic             st_we,
    output logic [PAW-1:0]   st_addr,
    output pixel_t           st_data
);

    logic [7:0] dim_q;

    always_ff @(posedge clk) begin
        if (rst)
            dim_q <= 8'd255;
        else if (dim_we)
            dim_q <= dim_level;
    end

    logic [31:0] wrapped;

    always_comb begin
        wrapped      = 32'(px_index) % 32'(PIXELS);
        st_addr      = PAW'(wrapped);
        st_we        = px_we;
        st_data.grn  = dim_scale(px_green, dim_q);
        st_data.red  = dim_scale(px_red,   dim_q);
        st_data.blu  = dim_scale(px_blue,  dim_q);
    end

    assert_wrap_R6: assert property (@(posedge clk) disable iff (rst)
        st_we |-> (32'(st_addr) < 32'(PIXELS)));

    assert_scale_R5: assert property (@(posedge clk) disable iff (rst)
        st_we |-> (st_data.grn <= px_green && st_data.red <= px_red && st_data.blu <= px_blue));

endmodule

// File: rtl/led_pixel_store.sv
module led_pixel_store
    import led_ser_pkg::*;
#(
    parameter int PIXELS = 8,
    parameter int PAW    = 3
) (
    input  logic           clk,
    input  logic           rst,
    input  logic           clr_all,
    input  logic           we,
    input  logic [PAW-1:0] waddr,
    input  pixel_t         wdata,
    input  logic [PAW-1:0] raddr,
    output pixel_t         rdata
);

    pixel_t mem [PIXELS];

    always_ff @(posedge clk) begin
        if (rst || clr_all) begin
            for (int i = 0; i < PIXELS; i++)
                mem[i] <= '0;
        end else if (we) begin
            mem[waddr] <= wdata;
        end
    end

    assign rdata = mem[raddr];

    assert_clear_R7: assert property (@(posedge clk) disable iff (rst)
        $past(clr_all) |-> (rdata == '0));

endmodule

// File: rtl/led_frame_seq.sv
module led_frame_seq
    import led_ser_pkg::*;
#(
    parameter int PIXELS    = 8,
    parameter int PAW       = 3,
    parameter int SLOT      = 125,
    parameter int T0H       = 41,
    parameter int T1H       = 82,
    parameter int GAP_SLOTS = 50
) (
    input  logic           clk,
    input  logic           rst,
    input  pixel_t         rdata,
    output logic [PAW-1:0] raddr,
    output logic           dout
);

    localparam int SW = $clog2(SLOT + 1);
    localparam int GW = $clog2(GAP_SLOTS + 1);
    localparam logic [SW-1:0]  SLOT_LAST = SW'(SLOT - 1);
    localparam logic [SW-1:0]  T0H_C     = SW'(T0H);
    localparam logic [SW-1:0]  T1H_C     = SW'(T1H);
    localparam logic [GW-1:0]  GAP_LAST  = GW'(GAP_SLOTS - 1);
    localparam logic [PAW-1:0] PIX_LAST  = PAW'(PIXELS - 1);
    localparam logic [4:0]     BIT_TOP   = 5'(BITS_PER_PIXEL - 1);

    phase_e         phase_q;
    logic [SW-1:0]  slot_cnt;
    logic [GW-1:0]  gap_cnt;
    logic [PAW-1:0] pix_idx;
    logic [4:0]     bit_idx;
    logic           bit_q;
    logic           dout_q;

    logic           cur_bit;
    logic           hi_bit;
    logic [SW-1:0]  hi_len;
    logic           last_slot;

    always_comb begin
        cur_bit   = rdata[bit_idx];
        hi_bit    = (slot_cnt == '0) ? cur_bit : bit_q;
        hi_len    = hi_bit ? T1H_C : T0H_C;
        last_slot = (slot_cnt == SLOT_LAST);
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            phase_q  <= PH_GAP;
            slot_cnt <= '0;
            gap_cnt  <= '0;
            pix_idx  <= '0;
            bit_idx  <= BIT_TOP;
            bit_q    <= 1'b0;
            dout_q   <= 1'b0;
        end else begin
            dout_q <= (phase_q == PH_DATA) && (slot_cnt < hi_len);
            if (phase_q == PH_DATA && slot_cnt == '0)
                bit_q <= cur_bit;
            if (last_slot) begin
                slot_cnt <= '0;
                case (phase_q)
                    PH_GAP: begin
                        if (gap_cnt == GAP_LAST) begin
                            gap_cnt <= '0;
                            phase_q <= PH_DATA;
                            pix_idx <= '0;
                            bit_idx <= BIT_TOP;
                        end else begin
                            gap_cnt <= gap_cnt + 1'b1;
                        end
                    end
                    default: begin
                        if (bit_idx == '0) begin
                            bit_idx <= BIT_TOP;
                            if (pix_idx == PIX_LAST)
                                phase_q <= PH_GAP;
                            else
                                pix_idx <= pix_idx + 1'b1;
                        end else begin
                            bit_idx <= bit_idx - 1'b1;
                        end
                    end
                endcase
            end else begin
                slot_cnt <= slot_cnt + 1'b1;
            end
        end
    end

    assign raddr = pix_idx;
    assign dout  = dout_q;

    assert_slot_range_R1: assert property (@(posedge clk) disable iff (rst)
        slot_cnt <= SLOT_LAST);

    assert_pulse_start_R2: assert property (@(posedge clk) disable iff (rst)
        $past(phase_q == PH_DATA && slot_cnt == '0) |-> dout_q);

    assert_pulse_end_R2: assert property (@(posedge clk) disable iff (rst)
        $past(phase_q == PH_DATA && slot_cnt >= T1H_C) |-> !dout_q);

    assert_pixel_range_R3: assert property (@(posedge clk) disable iff (rst)
        (pix_idx <= PIX_LAST) && (bit_idx <= BIT_TOP));

    assert_gap_low_R4: assert property (@(posedge clk) disable iff (rst)
        $past(phase_q == PH_GAP) |-> !dout_q);

endmodule

// File: rtl/led_strip_serializer.sv
module led_strip_serializer
    import led_ser_pkg::*;
#(
    parameter int PIXELS    = 8,
    parameter int CLK_HZ    = 100_000_000,
    parameter int IDX_W     = 8,
    parameter int GAP_SLOTS = 50
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             dim_we,
    input  logic [7:0]       dim_level,
    input  logic             px_we,
    input  logic [IDX_W-1:0] px_index,
    input  logic [7:0]       px_red,
    input  logic [7:0]       px_green,
    input  logic [7:0]       px_blue,
    input  logic             clr_all,
    output logic             led_dout
);

    localparam int SLOT = CLK_HZ / 800000;
    localparam int T0H  = SLOT / 3;
    localparam int T1H  = (SLOT / 3) * 2;
    localparam int PAW  = (PIXELS > 1) ? $clog2(PIXELS) : 1;

    logic           st_we;
    logic [PAW-1:0] st_addr;
    pixel_t         st_data;
    logic [PAW-1:0] rd_addr;
    pixel_t         rd_data;

    led_write_path #(
        .PIXELS (PIXELS),
        .IDX_W  (IDX_W),
        .PAW    (PAW)
    ) u_wr (
        .clk       (clk),
        .rst       (rst),
        .dim_we    (dim_we),
        .dim_level (dim_level),
        .px_we     (px_we),
        .px_index  (px_index),
        .px_red    (px_red),
        .px_green  (px_green),
        .px_blue   (px_blue),
        .st_we     (st_we),
        .st_addr   (st_addr),
        .st_data   (st_data)
    );

    led_pixel_store #(
        .PIXELS (PIXELS),
        .PAW    (PAW)
    ) u_store (
        .clk     (clk),
        .rst     (rst),
        .clr_all (clr_all),
        .we      (st_we),
        .waddr   (st_addr),
        .wdata   (st_data),
        .raddr   (rd_addr),
        .rdata   (rd_data)
    );

    led_frame_seq #(
        .PIXELS    (PIXELS),
        .PAW       (PAW),
        .SLOT      (SLOT),
        .T0H       (T0H),
        .T1H       (T1H),
        .GAP_SLOTS (GAP_SLOTS)
    ) u_seq (
        .clk   (clk),
        .rst   (rst),
        .rdata (rd_data),
        .raddr (rd_addr),
        .dout  (led_dout)
    );

endmodule

// File: tb/tb_led_strip_serializer.sv
`timescale 1ns/1ps
module tb_led_strip_serializer;

    localparam int NPIX   = 4;
    localparam int CLKHZ  = 12_000_000;
    localparam int IW     = 6;
    localparam int GAP    = 50;
    localparam int SLOT   = CLKHZ / 800000;
    localparam int T0     = SLOT / 3;
    localparam int T1     = (SLOT / 3) * 2;
    localparam int GAPPER = (GAP + 1) * SLOT;

    logic          clk = 0;
    logic          rst;
    logic          dim_we;
    logic [7:0]    dim_level;
    logic          px_we;
    logic [IW-1:0] px_index;
    logic [7:0]    px_red, px_green, px_blue;
    logic          clr_all;
    logic          led_dout;

    always #5 clk = ~clk;

    led_strip_serializer #(
        .PIXELS(NPIX), .CLK_HZ(CLKHZ), .IDX_W(IW), .GAP_SLOTS(GAP)
    ) dut (
        .clk(clk), .rst(rst), .dim_we(dim_we), .dim_level(dim_level),
        .px_we(px_we), .px_index(px_index), .px_red(px_red),
        .px_green(px_green), .px_blue(px_blue), .clr_all(clr_all),
        .led_dout(led_dout)
    );

    int total = 0;
    int bad   = 0;
    string cur_req = "R8";

    task automatic chk(input bit ok, input string req, input int act, input int exp);
        total++;
        if (!ok) begin
            bad++;
            $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
        end
    endtask

    // ---- reference model of the pixel store ----
    logic [23:0] model [NPIX];
    int          dim_m;

    function automatic logic [7:0] sc(input int v);
        return 8'((v * dim_m) / 256);
    endfunction

    // ---- scoreboard ----
    logic exp_q[$];
    int   cap_tok  = 0;
    int   cap_seen = 0;
    bit   capturing = 0;

    // ---- monitor ----
    logic prev = 0;
    int   cyc = 0, last_rise = 0, bits_in_frame = 0, first_rise = -1;
    bit   have_rise = 0;

    always @(negedge clk) begin
        if (rst) begin
            prev = 0; cyc = 0; have_rise = 0; bits_in_frame = 0;
        end else begin
            cyc++;
            if (led_dout && !prev) begin
                bit fstart;
                fstart = 0;
                if (!have_rise) begin
                    fstart = 1;
                    first_rise = cyc;
                end else begin
                    int per;
                    per = cyc - last_rise;
                    if (per == GAPPER) fstart = 1;
                    else chk(per == SLOT, "R1 pulse period", per, SLOT);
                end
                if (fstart) begin
                    if (have_rise)
                        chk(bits_in_frame == NPIX * 24, "R4 pulses per frame", bits_in_frame, NPIX * 24);
                    bits_in_frame = 0;
                    if (cap_seen != cap_tok && !capturing) begin
                        capturing = 1;
                        cap_seen  = cap_tok;
                    end
                end
                have_rise = 1;
                last_rise = cyc;
                bits_in_frame++;
            end
            if (!led_dout && prev) begin
                int w;
                w = cyc - last_rise;
                chk(w == T0 || w == T1, "R2 high time", w, T0);
                if (capturing && exp_q.size() > 0) begin
                    logic e;
                    e = exp_q.pop_front();
                    if (!(w == (e ? T1 : T0))) begin
                        total++; bad++;
                        $display("FAIL %s R3 bit %0d of frame: actual=%0d expected=%0d",
                                 cur_req, bits_in_frame - 1, (w == T1), e);
                    end else total++;
                    if (exp_q.size() == 0) capturing = 0;
                end
            end
            prev = led_dout;
        end
    end

    // ---- driver tasks ----
    task automatic write_px(input int idx, input int r, input int g, input int b);
        @(negedge clk);
        px_we = 1; px_index = IW'(idx);
        px_red = 8'(r); px_green = 8'(g); px_blue = 8'(b);
        model[idx % NPIX] = {sc(g), sc(r), sc(b)};
        @(negedge clk);
        px_we = 0;
    endtask

    task automatic set_dim(input int v);
        @(negedge clk);
        dim_we = 1; dim_level = 8'(v);
        dim_m = v;
        @(negedge clk);
        dim_we = 0;
    endtask

    task automatic do_clear();
        @(negedge clk);
        clr_all = 1;
        for (int p = 0; p < NPIX; p++) model[p] = '0;
        @(negedge clk);
        clr_all = 0;
    endtask

    task automatic expect_frame(input string tag);
        repeat (2) @(negedge clk);
        cur_req = tag;
        for (int p = 0; p < NPIX; p++)
            for (int b = 23; b >= 0; b--)
                exp_q.push_back(model[p][b]);
        cap_tok++;
        while (cap_seen != cap_tok || capturing) @(negedge clk);
    endtask

    task automatic finish_run();
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        chk(0, "watchdog expired", 0, 1);
        finish_run();
    end

    initial begin
        rst = 1; dim_we = 0; dim_level = 0; px_we = 0; px_index = 0;
        px_red = 0; px_green = 0; px_blue = 0; clr_all = 0;
        dim_m = 255;
        for (int p = 0; p < NPIX; p++) model[p] = '0;

        // R8: line low while reset is held
        repeat (6) begin
            @(negedge clk);
            chk(led_dout == 1'b0, "R8 line low in reset", led_dout, 0);
        end
        rst = 0;

        // R7 / R8: blank store after reset still sends short pulses
        expect_frame("R7_R8 blank frame");
        // R8: first pulse only after a full latch gap
        chk(first_rise >= GAP * SLOT - 1 && first_rise <= GAP * SLOT + 3,
            "R8 first pulse delay", first_rise, GAP * SLOT + 1);

        // R5 / R3: default dimming 255, distinct channel patterns
        write_px(0, 8'hFF, 8'h00, 8'h81);
        write_px(1, 8'h0F, 8'hA5, 8'h3C);
        write_px(2, 8'h80, 8'h01, 8'hFE);
        write_px(3, 8'h55, 8'hC3, 8'h00);
        expect_frame("R5_R3 default dim");

        // R6: out-of-range indices wrap
        write_px(NPIX + 1, 8'h12, 8'hF0, 8'h99);
        write_px(63, 8'hE7, 8'h18, 8'h66);
        expect_frame("R6 wrapped index");

        // R9: new dim level affects only later writes
        set_dim(128);
        write_px(2, 8'hFF, 8'hC8, 8'h03);
        expect_frame("R9 dim at write time");

        // R5: dim 0 gives a zero pixel
        set_dim(0);
        write_px(1, 8'hFF, 8'hFF, 8'hFF);
        expect_frame("R5 dim zero");

        // R7: clear beats a same-cycle write
        set_dim(255);
        @(negedge clk);
        clr_all = 1; px_we = 1; px_index = 0;
        px_red = 8'hFF; px_green = 8'hFF; px_blue = 8'hFF;
        for (int p = 0; p < NPIX; p++) model[p] = '0;
        @(negedge clk);
        clr_all = 0; px_we = 0;
        expect_frame("R7 clear");

        // R4: frames keep repeating with no host action
        write_px(3, 8'hAA, 8'h55, 8'hFF);
        expect_frame("R4 repeat 1");
        expect_frame("R4 repeat 2");

        finish_run();
    end

endmodule